// File: doc/BRIEF.md
# Down-Counting Timer with Complementary PWM

This block is a 16-bit timer/counter/PWM unit whose counter only ever counts down. A clock-enable input paces the count. The counter reloads from a period register when it is started, when a synchronous reload pulse arrives, and after it reaches zero. The counter value is compared against a compare register under one of five selectable relations. That compare result drives a raw PWM level, which is split into two complementary outputs separated by a programmable dead time. A kill input forces the compare-derived outputs low.

Three run modes are available: free-running, one-shot (stop after one period) and gated (count only while the gate input is high). The live count can be read on the fly, and a capture pulse latches the full count into a capture register. Terminal-count, compare-true and capture events set sticky status bits. These bits are cleared by writing ones, and the interrupt line is the OR of the enabled bits. Configuration goes through a simple synchronous write port.

Top module: `dcount_pwm`

## Requirements
- R1: While running, the count drops by exactly one at each clock where `tick_i` is high (and, in gated mode, `gate_i` is high). It holds on every other clock.
- R2: `cmp_o` is high when the count relates to the compare register (address 2) as selected by control bits [5:3]. The encodings are 0: less-than, 1: less-or-equal, 2: equal, 3: greater-or-equal, 4: greater-than. Any other code is never true.
- R3: The count loads the period register (address 1) in three cases: on the clock of a control write (address 0) that sets bit 0 (run) while stopped; on any clock where `reload_i` is high; and on the counting step that finds it at zero. `tc_o` is high for exactly that zero step.
- R4: Status bits (bit 0 terminal count, bit 1 compare-true on a counting step, bit 2 capture) are sticky. Writing ones to address 4 clears them. `irq_o` is the OR of the status bits whose enables are set in control bits [8:6], which follow the same bit order.
- R5: A high `cap_i` copies the count into `cap_o` at the next clock, without disturbing the count.
- R6: Control bits [2:1] select the run mode: 0 free-running, 1 one-shot, 2 gated. In one-shot mode the counter reloads at terminal count and then stops.
- R7: `pwm_hi_o` follows the raw compare level and `pwm_lo_o` its inverse. After each change of the registered raw level, both outputs are low for the number of clocks held in address 3 (8 bits). The two are never high together, and both are low while stopped.
- R8: While `kill_i` is high, `cmp_o`, `pwm_hi_o` and `pwm_lo_o` are low.
- R9: When a capture and a terminal count fall on the same clock, both status bits are set and `cap_o` holds zero, the value before the reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | Count enable (clock qualifier) |
| reload_i | input | 1 | Synchronous reload pulse |
| gate_i | input | 1 | Gate level for gated mode |
| cap_i | input | 1 | Capture request |
| kill_i | input | 1 | Forces compare-derived outputs low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| cnt_o | output | 16 | Live count |
| cap_o | output | 16 | Captured count |
| cmp_o | output | 1 | Compare result |
| tc_o | output | 1 | Terminal-count pulse |
| pwm_hi_o | output | 1 | True PWM output |
| pwm_lo_o | output | 1 | Complementary PWM output |
| irq_o | output | 1 | Interrupt request |
| stat_o | output | 3 | Sticky status bits |

## Verification
Capture and terminal count can land on the same clock. The bench provokes this by raising `cap_i` in the cycle where the count reads zero and `tc_o` is high. It then judges the following cycle: `cap_o` must read zero rather than the reloaded period, the count must show the period, and status bits 0 and 2 must both be set with the interrupt raised.

// File: rtl/dcount_pwm.sv
module dcount_pwm #(
  parameter int CW  = 16,
  parameter int DBW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          reload_i,
  input  logic          gate_i,
  input  logic          cap_i,
  input  logic          kill_i,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cap_o,
  output logic          cmp_o,
  output logic          tc_o,
  output logic          pwm_hi_o,
  output logic          pwm_lo_o,
  output logic          irq_o,
  output logic [2:0]    stat_o
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_PER  = 3'd1;
  localparam logic [2:0] A_CMP  = 3'd2;
  localparam logic [2:0] A_DB   = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [1:0] M_ONE  = 2'd1;
  localparam logic [1:0] M_GATE = 2'd2;

  logic          running;
  logic [1:0]    mode_q;
  logic [2:0]    rel_q, ie_q, stat_q;
  logic [CW-1:0] cnt_q, per_q, cmpv_q, cap_q;
  logic [DBW-1:0] db_q, dcnt_q;
  logic          raw, raw_r;

  wire wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
  wire start_ld = wr_ctrl && wr_data_i[0] && !running;
  wire step     = running && tick_i && ((mode_q != M_GATE) || gate_i);
  wire at_zero  = (cnt_q == '0);

  always_comb begin
    case (rel_q)
      3'd0:    raw = cnt_q <  cmpv_q;
      3'd1:    raw = cnt_q <= cmpv_q;
      3'd2:    raw = cnt_q == cmpv_q;
      3'd3:    raw = cnt_q >= cmpv_q;
      3'd4:    raw = cnt_q >  cmpv_q;
      default: raw = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rel_q  <= '0;
      ie_q   <= '0;
      per_q  <= '0;
      cmpv_q <= '0;
      db_q   <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL: begin
          mode_q <= wr_data_i[2:1];
          rel_q  <= wr_data_i[5:3];
          ie_q   <= wr_data_i[8:6];
        end
        A_PER:   per_q  <= wr_data_i;
        A_CMP:   cmpv_q <= wr_data_i;
        A_DB:    db_q   <= wr_data_i[DBW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (wr_ctrl)
        running <= wr_data_i[0];
      else if (step && at_zero && (mode_q == M_ONE))
        running <= 1'b0;
      if (reload_i || start_ld)
        cnt_q <= per_q;
      else if (step)
        cnt_q <= at_zero ? per_q : cnt_q - 1'b1;
    end
  end

  wire [2:0] st_set = {cap_i, step && raw, step && at_zero};
  wire [2:0] st_clr = (wr_en_i && (wr_addr_i == A_STAT)) ? wr_data_i[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      cap_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~st_clr) | st_set;
      if (cap_i) cap_q <= cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_r  <= 1'b0;
      dcnt_q <= '0;
    end else begin
      raw_r <= raw;
      if (raw != raw_r)
        dcnt_q <= db_q;
      else if (dcnt_q != '0)
        dcnt_q <= dcnt_q - 1'b1;
    end
  end

  wire live = running && (dcnt_q == '0) && !kill_i;

  assign cnt_o    = cnt_q;
  assign cap_o    = cap_q;
  assign cmp_o    = raw && !kill_i;
  assign tc_o     = step && at_zero;
  assign pwm_hi_o = live && raw_r;
  assign pwm_lo_o = live && !raw_r;
  assign stat_o   = stat_q;
  assign irq_o    = |(stat_q & ie_q);

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero && !reload_i && !start_ld) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R1
  AST_TC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero && !reload_i && !start_ld) |=> (cnt_q == $past(per_q))); // R3
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (cap_o == $past(cnt_o))); // R5
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero && (mode_q == M_ONE) && !wr_ctrl) |=> !running); // R6
  AST_PWM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_hi_o && pwm_lo_o)); // R7
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[0] && !(wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[0])) |=> stat_o[0]); // R4
endmodule

// File: tb/test_dcount_pwm.sv
`timescale 1ns/1ps
module test_dcount_pwm;
  logic clk = 1'b0;
  logic rst_n, tick_i, reload_i, gate_i, cap_i, kill_i, wr_en_i;
  logic [2:0] wr_addr_i;
  logic [15:0] wr_data_i, cnt_o, cap_o;
  logic cmp_o, tc_o, pwm_hi_o, pwm_lo_o, irq_o;
  logic [2:0] stat_o;
  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  dcount_pwm i_dcount_pwm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reload_i(reload_i), .gate_i(gate_i),
    .cap_i(cap_i), .kill_i(kill_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cnt_o(cnt_o), .cap_o(cap_o), .cmp_o(cmp_o), .tc_o(tc_o),
    .pwm_hi_o(pwm_hi_o), .pwm_lo_o(pwm_lo_o), .irq_o(irq_o), .stat_o(stat_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrl(input bit run, input int mode, input int rel, input int ie);
    return 16'((ie << 6) | (rel << 3) | (mode << 1) | int'(run));
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R3 reset cnt", cnt_o, 0);
    chk("R5 reset cap", cap_o, 0);
    chk("R4 reset stat/irq", {stat_o, irq_o}, 0);
    chk("R7 reset pwm", {pwm_hi_o, pwm_lo_o}, 0);
  endtask

  task automatic t_free;
    wr(1, 16'd5); wr(2, 16'hFFFF);
    wr(0, ctrl(1, 0, 4, 1));
    chk("R3 start load", cnt_o, 5);
    for (int k = 4; k >= 0; k--) begin
      @(negedge clk);
      chk("R1 count down", cnt_o, k);
      chk("R3 tc pulse", tc_o, (k == 0));
    end
    @(negedge clk);
    chk("R3 reload at zero", cnt_o, 5);
    chk("R4 tc sticky + irq", {stat_o, irq_o}, 4'b0011);
    tick_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1 hold without tick", cnt_o, 5);
    end
    tick_i = 1'b1;
    @(negedge clk);
    chk("R1 resume", cnt_o, 4);
    reload_i = 1'b1;
    @(negedge clk);
    reload_i = 1'b0;
    chk("R3 reload pulse", cnt_o, 5);
    wr(0, ctrl(0, 0, 4, 1));
    chk("R4 still sticky after stop", stat_o, 3'b001);
    wr(4, 16'd1);
    chk("R4 w1c clears", {stat_o, irq_o}, 0);
  endtask

  task automatic t_compare;
    logic exp;
    wr(1, 16'd10);
    reload_i = 1'b1;
    @(negedge clk);
    reload_i = 1'b0;
    chk("R3 reload while stopped", cnt_o, 10);
    for (int c = 9; c <= 11; c++) begin
      wr(2, 16'(c));
      for (int r = 0; r < 8; r++) begin
        wr(0, ctrl(0, 0, r, 0));
        case (r)
          0: exp = 10 <  c;
          1: exp = 10 <= c;
          2: exp = 10 == c;
          3: exp = 10 >= c;
          4: exp = 10 >  c;
          default: exp = 1'b0;
        endcase
        chk($sformatf("R2 rel %0d cmp %0d", r, c), cmp_o, exp);
      end
    end
  endtask

  task automatic t_oneshot;
    wr(1, 16'd3);
    wr(0, ctrl(1, 1, 4, 0));
    chk("R6 one-shot load", cnt_o, 3);
    for (int k = 2; k >= 0; k--) begin
      @(negedge clk);
      chk("R6 one-shot count", {cnt_o, tc_o}, {16'(k), (k == 0)});
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R6 one-shot stopped", {cnt_o, tc_o}, {16'd3, 1'b0});
    end
  endtask

  task automatic t_gated;
    wr(1, 16'd4);
    gate_i = 1'b0;
    wr(0, ctrl(1, 2, 4, 0));
    repeat (3) @(negedge clk);
    chk("R6 gated hold", cnt_o, 4);
    gate_i = 1'b1;
    @(negedge clk); chk("R6 gated count", cnt_o, 3);
    @(negedge clk); chk("R6 gated count", cnt_o, 2);
    gate_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 gated hold again", cnt_o, 2);
    wr(0, ctrl(0, 0, 4, 0));
  endtask

  task automatic t_capture;
    wr(4, 16'd7);
    wr(1, 16'd5);
    wr(0, ctrl(1, 0, 4, 5));
    @(negedge clk); @(negedge clk);
    chk("R5 pre-capture count", cnt_o, 3);
    cap_i = 1'b1;
    @(negedge clk);
    cap_i = 1'b0;
    chk("R5 captured value", cap_o, 3);
    chk("R5 count undisturbed", cnt_o, 2);
    chk("R4 capture status", stat_o, 3'b100);
    wr(4, 16'd7);
    chk("R4 w1c all", stat_o, 0);
    @(negedge clk);
    chk("R9 at zero", {cnt_o, tc_o}, {16'd0, 1'b1});
    cap_i = 1'b1;
    @(negedge clk);
    cap_i = 1'b0;
    chk("R9 capture before reload", cap_o, 0);
    chk("R9 reloaded", cnt_o, 5);
    chk("R9 both status + irq", {stat_o, irq_o}, 4'b1011);
    wr(0, ctrl(0, 0, 4, 0));
    wr(4, 16'd7);
  endtask

  task automatic t_deadband;
    int c, prv;
    logic [1:0] exp;
    wr(1, 16'd9); wr(2, 16'd5); wr(3, 16'd3);
    wr(0, ctrl(1, 0, 0, 0));
    repeat (10) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      c = int'(cnt_o);
      case (c)
        9, 0:     exp = 2'b10;
        5, 4:     exp = 2'b01;
        default:  exp = 2'b00;
      endcase
      chk($sformatf("R7 deadband 3 at cnt %0d", c), {pwm_hi_o, pwm_lo_o}, exp);
      @(negedge clk);
    end
    wr(3, 16'd0);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      c = int'(cnt_o);
      prv = (c == 9) ? 0 : c + 1;
      exp = (prv < 5) ? 2'b10 : 2'b01;
      chk($sformatf("R7 no deadband at cnt %0d", c), {pwm_hi_o, pwm_lo_o}, exp);
      @(negedge clk);
    end
    kill_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R8 kill forces low", {cmp_o, pwm_hi_o, pwm_lo_o}, 0);
    end
    kill_i = 1'b0;
    @(negedge clk);
    chk("R8 release restores", pwm_hi_o ^ pwm_lo_o, 1);
    wr(0, ctrl(0, 0, 0, 0));
    chk("R7 stopped outputs low", {pwm_hi_o, pwm_lo_o}, 0);
  endtask

  initial begin
    rst_n = 1'b0; tick_i = 1'b1; reload_i = 1'b0; gate_i = 1'b0; cap_i = 1'b0;
    kill_i = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_free;
    t_compare;
    t_oneshot;
    t_gated;
    t_capture;
    t_deadband;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule